// File: doc/BRIEF.md
# Interrupt-Capable 32-Pin I/O Port

This block is a 32-pin general-purpose I/O port behind a word-addressed register interface. Software sets an output value and a direction bit for each pin, reads back the synchronised pad levels, and gives each pin one of four trigger modes. Every pad input passes through a two-flop synchroniser before event detection. Detected events are latched in a status word that software clears by writing ones.

A mask word decides which latched events reach the interrupt outputs. By default there are two interrupt lines: one serves pins 0 to 15 and the other serves pins 16 to 31. When the parameter `SPLIT_IRQ` is 0, a single line serves all 32 pins and the second line is tied low.

The bus is a plain strobe interface. A write with `bus_wr` high takes effect at the next rising clock edge. Read data is combinational from `bus_addr`. The word index is the byte offset divided by four: 0 data, 1 direction, 2 pad level, 3 trigger config for pins 0-15, 4 trigger config for pins 16-31, 5 mask, 6 status. Index 7 reads as zero.

Top module: `gp_irq_port`

## Requirements
- R1: While reset is held, data, direction, both trigger words, mask and status all read zero, and both interrupt outputs are low.
- R2: `pad_out` equals the data word and `pad_oe` equals the direction word. Reading word 0 returns the written data, not the pad level.
- R3: Word 2 returns `pad_in` delayed by two clock edges. Writes to word 2 have no effect.
- R4: Pin p uses the 2-bit field at bits 2*(p mod 16)+1 : 2*(p mod 16). Pins 0-15 use word 3 and pins 16-31 use word 4. Both words read back as written.
- R5: Code 0 is low level and code 1 is high level. In a level mode the status bit is set on every cycle the synchronised level is present, so a clear has no lasting effect while the level persists. A change at `pad_in` is first visible in status three edges later.
- R6: Code 2 is rising edge and code 3 is falling edge. Each edge of the synchronised input sets the status bit once. The opposite edge sets nothing.
- R7: Writing word 6 clears every status bit written as 1 and leaves bits written as 0 unchanged. A new event in the same cycle as the clear wins.
- R8: A mask bit of 1 enables its pin. `irq_lo` is the OR of set-and-enabled status bits 0-15, and `irq_hi` is the same for bits 16-31.
- R9: Rewriting a pin's trigger field does not by itself set its status bit. The edge history keeps tracking the input in every mode.
- R10: With `SPLIT_IRQ` = 0, `irq_lo` is the OR over all 32 enabled status bits and `irq_hi` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 32 | Raw pad levels |
| pad_out | output | 32 | Output data to pads |
| pad_oe | output | 32 | Output enables to pads |
| irq_lo | output | 1 | Interrupt for pins 0-15, or for all pins when merged |
| irq_hi | output | 1 | Interrupt for pins 16-31 |

## Verification
The bench clears a level-mode bit while the level is still present. A design that lets the clear win would show the bit as zero. It also rewrites a pin from rising to falling mode while the pad is high. A design that freezes or reloads its edge history would then latch a false event. Pins 5 and 20 check the field placement and the half split: a wrong field offset sets status for the wrong pin, and a wrong split raises the wrong interrupt line. A second instance with merged interrupts confirms that an upper-half event reaches the single line.

// File: rtl/gp_port_pkg.sv
package gp_port_pkg;
    localparam int PORT_W = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_RISE = 2'd2,
        TRIG_FALL = 2'd3
    } trig_e;

    localparam logic [ADDR_W-1:0] REG_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] REG_DIR  = 3'd1;
    localparam logic [ADDR_W-1:0] REG_PAD  = 3'd2;
    localparam logic [ADDR_W-1:0] REG_CFGL = 3'd3;
    localparam logic [ADDR_W-1:0] REG_CFGH = 3'd4;
    localparam logic [ADDR_W-1:0] REG_MASK = 3'd5;
    localparam logic [ADDR_W-1:0] REG_STAT = 3'd6;

    typedef struct packed {
        logic [PORT_W-1:0] data;
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] cfg_lo;
        logic [PORT_W-1:0] cfg_hi;
        logic [PORT_W-1:0] mask;
        logic [PORT_W-1:0] status;
    } port_regs_t;
endpackage

// File: rtl/gp_sync.sv
module gp_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = raw_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gp_event.sv
module gp_event
    import gp_port_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   level,
    input  logic [2*W-1:0] trig_cfg,
    output logic [W-1:0]   event_hit
);
    logic [W-1:0] hist_d, hist_q;
    logic [W-1:0] rise_mode;

    // History follows the synchronised input regardless of mode
    assign hist_d = level;

    for (genvar p = 0; p < W; p++) begin : g_pin
        always_comb begin
            rise_mode[p] = 1'b0;
            case (trig_e'(trig_cfg[2*p +: 2]))
                TRIG_LOW:  event_hit[p] = ~level[p];
                TRIG_HIGH: event_hit[p] = level[p];
                TRIG_RISE: begin
                    event_hit[p] = level[p] & ~hist_q[p];
                    rise_mode[p] = 1'b1;
                end
                default:   event_hit[p] = ~level[p] & hist_q[p];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    AST_RISE_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (event_hit & $past(event_hit) & rise_mode & $past(rise_mode)) == '0); // R6
endmodule

// File: rtl/gp_irq_port.sv
module gp_irq_port
    import gp_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit SPLIT_IRQ   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    output logic              irq_lo,
    output logic              irq_hi
);
    port_regs_t        st_d, st_q;
    logic [PORT_W-1:0] pad_sync;
    logic [PORT_W-1:0] evt;
    logic [PORT_W-1:0] clr_bits;
    logic [PORT_W-1:0] pending;

    gp_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .raw_in(pad_in), .sync_out(pad_sync)
    );

    gp_event #(.W(PORT_W)) event_i (
        .clk(clk), .rst_n(rst_n), .level(pad_sync),
        .trig_cfg({st_q.cfg_hi, st_q.cfg_lo}), .event_hit(evt)
    );

    always_comb begin
        st_d     = st_q;
        clr_bits = '0;
        if (bus_wr) begin
            case (bus_addr)
                REG_DATA: st_d.data   = bus_wdata;
                REG_DIR:  st_d.dir    = bus_wdata;
                REG_CFGL: st_d.cfg_lo = bus_wdata;
                REG_CFGH: st_d.cfg_hi = bus_wdata;
                REG_MASK: st_d.mask   = bus_wdata;
                REG_STAT: clr_bits    = bus_wdata;
                default:  ;
            endcase
        end
        st_d.status = (st_q.status & ~clr_bits) | evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (bus_addr)
            REG_DATA: bus_rdata = st_q.data;
            REG_DIR:  bus_rdata = st_q.dir;
            REG_PAD:  bus_rdata = pad_sync;
            REG_CFGL: bus_rdata = st_q.cfg_lo;
            REG_CFGH: bus_rdata = st_q.cfg_hi;
            REG_MASK: bus_rdata = st_q.mask;
            REG_STAT: bus_rdata = st_q.status;
            default:  bus_rdata = '0;
        endcase
    end

    assign pad_out = st_q.data;
    assign pad_oe  = st_q.dir;
    assign pending = st_q.status & st_q.mask;

    if (SPLIT_IRQ) begin : g_split
        localparam int HALF = PORT_W / 2;
        assign irq_lo = |pending[HALF-1:0];
        assign irq_hi = |pending[PORT_W-1:HALF];
    end else begin : g_merged
        assign irq_lo = |pending;
        assign irq_hi = 1'b0;
    end

    AST_NO_SET_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.status & ~$past(st_q.status)) & ~$past(evt)) == '0); // R7
    AST_CLEAR_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.status & $past(clr_bits) & ~$past(evt)) == '0); // R7
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> (st_q.mask != '0)); // R8
    AST_HI_ONLY_WHEN_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> SPLIT_IRQ); // R10
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == REG_DIR) |=> $stable(pad_oe)); // R2
endmodule

// File: tb/gp_irq_port_tb.sv
`timescale 1ns/1ps
module gp_irq_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] pad_in = '0;
    logic [31:0] rdata, pad_out, pad_oe, rdata_m, pad_out_m, pad_oe_m;
    logic        irq_lo, irq_hi, irq_lo_m, irq_hi_m;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    gp_irq_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    gp_irq_port #(.SPLIT_IRQ(1'b0)) dut_m (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_m), .pad_in(pad_in),
        .pad_out(pad_out_m), .pad_oe(pad_oe_m), .irq_lo(irq_lo_m), .irq_hi(irq_hi_m)
    );

    // {word index, write data, expected readback}
    localparam logic [66:0] VEC [6] = '{
        {3'd0, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
        {3'd1, 32'hFFFF_0000, 32'hFFFF_0000},
        {3'd3, 32'h1234_5678, 32'h1234_5678},
        {3'd4, 32'h9ABC_DEF0, 32'h9ABC_DEF0},
        {3'd5, 32'h0000_0000, 32'h0000_0000},
        {3'd2, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = rdata;
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        tick(3);
        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            if (a != 2) begin
                rd(3'(a), v);
                check("R1 reg", v, 32'h0);
            end
        end
        check("R1 irq", {30'd0, irq_hi, irq_lo}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R4 table walk
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][66:64], VEC[i][63:32]);
            rd(VEC[i][66:64], v);
            check("R4 table readback", v, VEC[i][31:0]);
        end
        check("R2 pad_out", pad_out, 32'hA5A5_0F0F);
        check("R2 pad_oe", pad_oe, 32'hFFFF_0000);

        // all pins high-level, pads low: nothing pending after clear
        wr(3'd3, 32'h5555_5555);
        wr(3'd4, 32'h5555_5555);
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd6, v); check("R7 clear all", v, 32'h0);

        // R3 synchroniser latency, R5 high level
        pad_in[3] = 1'b1;
        tick(1); rd(3'd2, v); check("R3 pad after 1", v, 32'h0);
        tick(1); rd(3'd2, v); check("R3 pad after 2", v, 32'h8);
        rd(3'd6, v); check("R5 not yet", v, 32'h0);
        tick(1); rd(3'd6, v); check("R5 high level set", v, 32'h8);
        rd(3'd0, v); check("R2 data not pad", v, 32'hA5A5_0F0F);
        wr(3'd6, 32'h8);
        rd(3'd6, v); check("R5 R7 event wins", v, 32'h8);
        pad_in[3] = 1'b0;
        tick(3);
        wr(3'd6, 32'h8);
        rd(3'd6, v); check("R5 clear after level gone", v, 32'h0);

        // R4 R5 low level on pin 20 (high word bits 9:8)
        wr(3'd4, 32'h5555_5455);
        tick(1);
        rd(3'd6, v); check("R4 R5 low level pin20", v, 32'h0010_0000);
        wr(3'd4, 32'h5555_5555);
        wr(3'd6, 32'h0010_0000);
        rd(3'd6, v); check("R7 pin20 cleared", v, 32'h0);

        // R6 rising on pin 5 (low word bits 11:10)
        wr(3'd3, 32'h5555_5955);
        pad_in[5] = 1'b1;
        tick(3);
        rd(3'd6, v); check("R6 rising set", v, 32'h20);
        wr(3'd6, 32'h20);
        tick(3);
        rd(3'd6, v); check("R6 once per edge", v, 32'h0);

        // R9 switch to falling while high: no event
        wr(3'd3, 32'h5555_5D55);
        tick(3);
        rd(3'd6, v); check("R9 no spurious event", v, 32'h0);
        pad_in[5] = 1'b0;
        tick(3);
        rd(3'd6, v); check("R6 falling set", v, 32'h20);

        // R8 masking and split lines
        check("R8 masked off", {30'd0, irq_hi, irq_lo}, 32'h0);
        wr(3'd5, 32'h20);
        check("R8 lower line", {30'd0, irq_hi, irq_lo}, 32'h1);
        wr(3'd4, 32'h5555_5455);
        tick(1);
        wr(3'd5, 32'h0010_0000);
        check("R8 upper line", {30'd0, irq_hi, irq_lo}, 32'h2);
        check("R10 merged line", {30'd0, irq_hi_m, irq_lo_m}, 32'h1);

        // R7 zeros leave bits, ones clear
        wr(3'd6, 32'h0);
        rd(3'd6, v); check("R7 zero write keeps", v, 32'h0010_0020);
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd6, v); check("R7 ones clear, level persists", v, 32'h0010_0000);

        done = 1'b1;
        finish_run();
    end
endmodule